// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block holds the modem status byte of a serial port controller. Four active-low modem control pins (clear-to-send, data-set-ready, ring, carrier-detect) are synchronised, their asserted levels are shown on the upper nibble of an 8-bit read port, and transitions on them are caught in four sticky flags on the lower nibble. A CPU read strobe returns the byte and clears the flags. A modem status interrupt request follows the flags when its enable is set.

A loopback control replaces the pins with four modem control register bits, routed in a crossed order. Edge detection then runs on the looped values. An auto-flow enable keeps the clear-to-send change flag at zero. A small mode state machine tracks the active source. It has three states: `ST_INIT` (first cycle after reset), `ST_EXT` (pins feed the status) and `ST_LOOP` (control bits feed the status). Its transitions are: init-to-ext or init-to-loop, taken unconditionally after one cycle according to the loopback control; ext-to-loop when loopback rises; loop-to-ext when it falls. Detection is suppressed in `ST_INIT` and in any cycle where loopback disagrees with the state, so neither reset nor a change of source raises a flag.

Top module: `modem_status_reg`

## Requirements
- R1: Flag bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier-detect) set when the matching pin changes level in either direction.
- R2: Flag bit 2 sets only when the ring pin goes from low to high (in loopback: when its looped bit goes from 1 to 0); the opposite transition sets nothing.
- R3: Outside loopback, bits 4, 5, 6, 7 equal the inverted clear-to-send, data-set-ready, ring and carrier-detect pins. A pin change shows there after two rising clock edges, and its flag after the third.
- R4: With loopback at 1, bit 4 = control bit 1, bit 5 = control bit 0, bit 6 = control bit 2, bit 7 = control bit 3. The mapping is combinational.
- R5: A cycle with the read strobe at 1 returns the current byte, and the four flags read 0 after that edge.
- R6: A change event in the same cycle as a read keeps its flag set after the read.
- R7: While auto-flow is 1, flag bit 0 reads 0 one edge later and stays 0, and no interrupt comes from it.
- R8: The interrupt request equals the interrupt enable ANDed with the OR of the four flags.
- R9: In loopback, pin changes set no flag, while changes of the looped control bits are detected.
- R10: After reset, and after any switch of loopback, all flags are 0 until a real change occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| ri_n_i | input | 1 | Ring pin, active low |
| dcd_n_i | input | 1 | Carrier-detect pin, active low |
| mcr_ctl_i | input | 4 | Modem control bits: 0 DTR, 1 RTS, 2 OUT1, 3 OUT2 |
| loop_en_i | input | 1 | Loopback enable |
| autoflow_en_i | input | 1 | Auto-flow enable |
| msi_en_i | input | 1 | Modem status interrupt enable |
| rd_stb_i | input | 1 | CPU read strobe |
| rd_data_o | output | 8 | Status byte: 7:4 levels, 3:0 change flags |
| irq_o | output | 1 | Modem status interrupt request |

## Verification
A new change event and the clearing by a CPU read can fall on the same clock edge. The bench provokes this in two ways. In loopback, a control bit and the read strobe are driven at the same falling edge. From a pin, the strobe is raised exactly two edges after the pin change, so the event reaches the flag on the read edge. The result is correct when the read returns the flags as they stood before the event, and afterwards only the new event's flag is set while the earlier flags are cleared.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int unsigned MSR_LINES  = 4;
    localparam int unsigned SYNC_DEPTH = 2;
    // status line order (also upper-nibble order)
    localparam int unsigned IDX_CTS = 0;
    localparam int unsigned IDX_DSR = 1;
    localparam int unsigned IDX_RI  = 2;
    localparam int unsigned IDX_DCD = 3;
    // modem control bit positions
    localparam int unsigned MCR_DTR  = 0;
    localparam int unsigned MCR_RTS  = 1;
    localparam int unsigned MCR_OUT1 = 2;
    localparam int unsigned MCR_OUT2 = 3;
    // lines detected on trailing (1 -> 0 of asserted level) only
    localparam logic [MSR_LINES-1:0] TRAIL_ONLY = 4'b0100;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_EXT  = 2'd1,
        ST_LOOP = 2'd2
    } msr_mode_e;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msr_src_sel.sv
module msr_src_sel
    import msr_pkg::*;
(
    input  logic [MSR_LINES-1:0] pin_n_i,
    input  logic [MSR_LINES-1:0] mcr_i,
    input  logic                 loop_i,
    output logic [MSR_LINES-1:0] level_o
);
    logic [MSR_LINES-1:0] ext_level;
    logic [MSR_LINES-1:0] lpb_level;

    always_comb begin
        ext_level          = ~pin_n_i;
        lpb_level[IDX_CTS] = mcr_i[MCR_RTS];
        lpb_level[IDX_DSR] = mcr_i[MCR_DTR];
        lpb_level[IDX_RI]  = mcr_i[MCR_OUT1];
        lpb_level[IDX_DCD] = mcr_i[MCR_OUT2];
        level_o            = loop_i ? lpb_level : ext_level;
    end
endmodule

// File: rtl/msr_edge_det.sv
module msr_edge_det #(
    parameter int unsigned        WIDTH      = 4,
    parameter logic [WIDTH-1:0]   TRAIL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             detect_en_i,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] evt_o
);
    logic [WIDTH-1:0] prev_q;

    // previous level tracks the live level, also during reset
    always_ff @(posedge clk) begin
        prev_q <= level_i;
    end

    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        if (TRAIL_MASK[k]) begin : g_trail
            assign evt_o[k] = detect_en_i & prev_q[k] & ~level_i[k];

            // R2: a rising asserted level never raises the trailing flag
            assert_ri_no_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (!prev_q[k] && level_i[k]) |-> !evt_o[k]);
        end else begin : g_toggle
            assign evt_o[k] = detect_en_i & (prev_q[k] ^ level_i[k]);
        end
    end
endmodule

// File: rtl/msr_flag_bank.sv
module msr_flag_bank #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_i,
    input  logic [WIDTH-1:0] hold_clr_i,
    input  logic             rd_i,
    output logic [WIDTH-1:0] flag_o
);
    logic [WIDTH-1:0] flag_q;
    logic [WIDTH-1:0] flag_d;
    logic [WIDTH-1:0] keep_evt;

    assign keep_evt = evt_i & ~hold_clr_i;

    always_comb begin
        flag_d = rd_i ? '0 : flag_q;
        flag_d = (flag_d | evt_i) & ~hold_clr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R5: after a read only flags fed by a same-cycle event remain
    assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> ((flag_q & ~$past(evt_i)) == '0));

    // R6: an event is never lost, even when it meets a read
    assert_event_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_evt != '0) |=> ((flag_q & $past(keep_evt)) == $past(keep_evt)));
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
    import msr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_n_i,
    input  logic       dsr_n_i,
    input  logic       ri_n_i,
    input  logic       dcd_n_i,
    input  logic [3:0] mcr_ctl_i,
    input  logic       loop_en_i,
    input  logic       autoflow_en_i,
    input  logic       msi_en_i,
    input  logic       rd_stb_i,
    output logic [7:0] rd_data_o,
    output logic       irq_o
);
    localparam int unsigned W = MSR_LINES;

    msr_mode_e      state_q;
    msr_mode_e      state_d;
    logic           detect_en;
    logic [W-1:0]   pin_raw_n;
    logic [W-1:0]   pin_sync_n;
    logic [W-1:0]   level;
    logic [W-1:0]   evt;
    logic [W-1:0]   hold_clr;
    logic [W-1:0]   flags;

    always_comb begin
        pin_raw_n          = '1;
        pin_raw_n[IDX_CTS] = cts_n_i;
        pin_raw_n[IDX_DSR] = dsr_n_i;
        pin_raw_n[IDX_RI]  = ri_n_i;
        pin_raw_n[IDX_DCD] = dcd_n_i;
    end

    msr_sync #(.WIDTH(W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .d_i (pin_raw_n),
        .q_o (pin_sync_n)
    );

    msr_src_sel u_sel (
        .pin_n_i (pin_sync_n),
        .mcr_i   (mcr_ctl_i),
        .loop_i  (loop_en_i),
        .level_o (level)
    );

    // mode state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: state_d = loop_en_i ? ST_LOOP : ST_EXT;
            ST_EXT:  if (loop_en_i)  state_d = ST_LOOP;
            ST_LOOP: if (!loop_en_i) state_d = ST_EXT;
            default: state_d = ST_INIT;
        endcase
    end

    // outputs of the mode machine
    always_comb begin
        detect_en = 1'b0;
        unique case (state_q)
            ST_INIT: detect_en = 1'b0;
            ST_EXT:  detect_en = !loop_en_i;
            ST_LOOP: detect_en = loop_en_i;
            default: detect_en = 1'b0;
        endcase
    end

    msr_edge_det #(.WIDTH(W), .TRAIL_MASK(TRAIL_ONLY)) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .detect_en_i (detect_en),
        .level_i     (level),
        .evt_o       (evt)
    );

    always_comb begin
        hold_clr          = '0;
        hold_clr[IDX_CTS] = autoflow_en_i;
    end

    msr_flag_bank #(.WIDTH(W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .hold_clr_i (hold_clr),
        .rd_i       (rd_stb_i),
        .flag_o     (flags)
    );

    assign rd_data_o = {level, flags};
    assign irq_o     = msi_en_i & (|flags);

    // R7: auto-flow keeps the clear-to-send flag low on the next edge
    assert_autoflow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        autoflow_en_i |=> !rd_data_o[IDX_CTS]);

    // R8: no request while the enable is low
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_en_i |-> !irq_o);

    // R10: the post-reset cycle raises no flag
    assert_init_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |=> (flags == '0));

    // R10: a source switch raises no flag on its edge
    assert_switch_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EXT && loop_en_i) || (state_q == ST_LOOP && !loop_en_i)) && !autoflow_en_i
        |=> ((flags & ~$past(flags)) == '0));
endmodule

// File: tb/modem_status_reg_tb.sv
module modem_status_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_n = 1'b0;
    logic       dsr_n = 1'b1;
    logic       ri_n = 1'b1;
    logic       dcd_n = 1'b1;
    logic [3:0] mcr = 4'b0000;
    logic       loop_en = 1'b0;
    logic       af_en = 1'b0;
    logic       msi_en = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    modem_status_reg u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cts_n_i       (cts_n),
        .dsr_n_i       (dsr_n),
        .ri_n_i        (ri_n),
        .dcd_n_i       (dcd_n),
        .mcr_ctl_i     (mcr),
        .loop_en_i     (loop_en),
        .autoflow_en_i (af_en),
        .msi_en_i      (msi_en),
        .rd_stb_i      (rd),
        .rd_data_o     (rd_data),
        .irq_o         (irq)
    );

    function automatic logic [3:0] exp_upper();
        if (loop_en) return {mcr[3], mcr[2], mcr[0], mcr[1]};
        return {~dcd_n, ~ri_n, ~dsr_n, ~cts_n};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag, input logic [3:0] exp);
        chk(tag, {4'h0, rd_data[3:0]}, {4'h0, exp});
    endtask

    task automatic chk_upper(input string tag);
        chk(tag, {4'h0, rd_data[7:4]}, {4'h0, exp_upper()});
    endtask

    task automatic do_read(input string tag, input logic [3:0] exp);
        rd = 1'b1;
        #1;
        chk_flags({tag, " R5 read value"}, exp);
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
        #1;
        chk_flags({tag, " R5 cleared"}, 4'h0);
    endtask

    task automatic t_reset();
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick(3);
        chk_flags("R10 flags after reset", 4'h0);
        chk_upper("R3 levels after reset");
        chk({7'h0, irq}, {7'h0, irq}, 8'h00);
    endtask

    task automatic t_toggle_r1();
        @(negedge clk); dsr_n = 1'b0;
        tick(2);
        chk_upper("R3 level after two edges");
        chk_flags("R3 no flag before third edge", 4'h0);
        tick(1);
        chk_flags("R1 dsr fall", 4'b0010);
        do_read("R1 dsr", 4'b0010);
        dsr_n = 1'b1; tick(3);
        chk_flags("R1 dsr rise", 4'b0010);
        do_read("R1 dsr2", 4'b0010);
        cts_n = 1'b1; tick(3);
        chk_flags("R1 cts rise", 4'b0001);
        do_read("R1 cts", 4'b0001);
        dcd_n = 1'b0; tick(3);
        chk_flags("R1 dcd fall", 4'b1000);
        do_read("R1 dcd", 4'b1000);
        dcd_n = 1'b1; tick(3);
        chk_flags("R1 dcd rise", 4'b1000);
        chk_upper("R3 levels after toggles");
        do_read("R1 dcd2", 4'b1000);
    endtask

    task automatic t_ring_r2();
        ri_n = 1'b0; tick(3);
        chk_flags("R2 ring pin fall ignored", 4'h0);
        chk_upper("R3 ring level");
        tick(2);
        chk_flags("R2 ring pin fall still ignored", 4'h0);
        ri_n = 1'b1; tick(3);
        chk_flags("R2 ring pin rise", 4'b0100);
        do_read("R2 ring", 4'b0100);
    endtask

    task automatic t_irq_r8();
        msi_en = 1'b0;
        cts_n = 1'b0; tick(3);
        chk_flags("R8 flag set", 4'b0001);
        chk({7'h0, irq}, {7'h0, irq}, 8'h00);
        msi_en = 1'b1; #1;
        chk({7'h0, irq}, 8'h01, 8'h01);
        chk({7'h0, irq}, {7'h0, irq}, 8'h01);
        do_read("R8", 4'b0001);
        chk({7'h0, irq}, {7'h0, irq}, 8'h00);
        dsr_n = 1'b0; dcd_n = 1'b0; tick(3);
        chk_flags("R1 two lines at once", 4'b1010);
        chk({7'h0, irq}, {7'h0, irq}, 8'h01);
        do_read("R5 all at once", 4'b1010);
    endtask

    task automatic t_autoflow_r7();
        af_en = 1'b1;
        cts_n = 1'b1; tick(3);
        chk_flags("R7 cts rise suppressed", 4'h0);
        chk({7'h0, irq}, {7'h0, irq}, 8'h00);
        cts_n = 1'b0; tick(3);
        chk_flags("R7 cts fall suppressed", 4'h0);
        af_en = 1'b0;
        cts_n = 1'b1; tick(3);
        chk_flags("R1 cts with auto-flow off", 4'b0001);
        af_en = 1'b1; tick(1);
        chk_flags("R7 set flag cleared", 4'h0);
        chk({7'h0, irq}, {7'h0, irq}, 8'h00);
        af_en = 1'b0; tick(1);
        chk_flags("R7 stays clear", 4'h0);
    endtask

    task automatic t_loop_r4_r9();
        loop_en = 1'b1; mcr = 4'b0000; tick(3);
        chk_flags("R10 switch into loopback", 4'h0);
        chk_upper("R4 all control bits low");
        mcr = 4'b0001; #1; chk("R4 DTR to bit 5", {4'h0, rd_data[7:4]}, 8'h02); tick(1);
        mcr = 4'b0010; #1; chk("R4 RTS to bit 4", {4'h0, rd_data[7:4]}, 8'h01); tick(1);
        mcr = 4'b0100; #1; chk("R4 OUT1 to bit 6", {4'h0, rd_data[7:4]}, 8'h04); tick(1);
        mcr = 4'b1000; #1; chk("R4 OUT2 to bit 7", {4'h0, rd_data[7:4]}, 8'h08); tick(1);
        rd = 1'b1; tick(1); rd = 1'b0; tick(1);
        chk_flags("R5 cleared in loopback", 4'h0);
        cts_n = ~cts_n; dsr_n = ~dsr_n; ri_n = ~ri_n; dcd_n = ~dcd_n;
        tick(4);
        chk_flags("R9 pins ignored in loopback", 4'h0);
        chk_upper("R9 levels from control bits");
        mcr = 4'b0000; tick(1);
        chk_flags("R9 looped OUT2 change", 4'b1000);
        do_read("R9", 4'b1000);
        mcr = 4'b0100; tick(1);
        chk_flags("R2 looped leading edge ignored", 4'h0);
        mcr = 4'b0000; tick(1);
        chk_flags("R2 looped trailing edge", 4'b0100);
        do_read("R2 loop", 4'b0100);
    endtask

    task automatic t_collide_r6();
        mcr = 4'b0001; rd = 1'b1; #1;
        chk_flags("R6 read sees old flags", 4'h0);
        tick(1); rd = 1'b0; #1;
        chk_flags("R6 looped event kept", 4'b0010);
        do_read("R6 loop", 4'b0010);
        loop_en = 1'b0; tick(3);
        chk_flags("R10 switch out of loopback", 4'h0);
        chk_upper("R3 pins again");
        dsr_n = ~dsr_n; tick(3);
        chk_flags("R1 dsr before collision", 4'b0010);
        dcd_n = ~dcd_n; tick(2);
        chk_flags("R6 dcd not yet", 4'b0010);
        rd = 1'b1; tick(1); rd = 1'b0; #1;
        chk_flags("R6 pin event kept, other cleared", 4'b1000);
        do_read("R6 pin", 4'b1000);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_toggle_r1();
        t_ring_r2();
        t_irq_r8();
        t_autoflow_r7();
        t_loop_r4_r9();
        t_collide_r6();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule